// File: doc/BRIEF.md
# Triggered Multichannel Waveform Capture

This block records converter samples from a bank of channels into an on-chip sample memory. Software programs a channel mask, a decimation rate, a post-trigger delay, a trigger source and a sample count per channel, then arms the block with a single write. Once the trigger condition is met and any delay has elapsed, every accepted base tick produces one sample set: the words of the enabled channels written to consecutive memory addresses, lowest channel number first. The write port is meant to feed a simple dual-port RAM whose read side belongs to the host.

The trigger can fire at once, on the next setpoint write, when every channel has finished ramping, or on an external event pulse. Capture ends when the requested number of sample sets has been stored, when software aborts it, or when the next write would fall outside the memory. Each of these endings clears the busy flag, which doubles as the readback of the self-clearing arm bit, and produces a one-cycle completion pulse. The count of enabled channels and the memory size in units of 1024 words are offered for status readback.

The controller is a five-state machine. IDLE goes to ARMED on an arm write, latching the configuration. ARMED goes to WAIT_TICK when the trigger fires and no delay applies, to DELAY when the trigger fires with a nonzero delay outside immediate mode, and to IDLE on abort. DELAY goes to WAIT_TICK on the base tick that completes the delay, and to IDLE on abort. WAIT_TICK goes to SCAN on a base tick accepted by the decimator, and to IDLE on abort. SCAN stays in SCAN while enabled channels remain in the current set, returns to WAIT_TICK when the set is finished and more sets are due, and goes to IDLE after the final set, on abort, or when the memory is full.

Top module: `wave_capture`

## Requirements
- R1: After reset, busy, mem_we and done_pulse are all 0.
- R2: An arm write while idle sets busy on the next cycle and latches cfg_mode, cfg_mask, cfg_rate, cfg_delay and cfg_samples; an arm write while busy is ignored (the address sequence continues undisturbed).
- R3: In immediate mode (cfg_mode = 0) the first base tick after arming is stored, whatever cfg_delay holds.
- R4: In ramp-start mode (cfg_mode = 1) base ticks are not stored until a setpoint_wr pulse arrives after arming.
- R5: In ramp-end mode (cfg_mode = 2) the trigger is a 1-to-0 change of the OR of all ramping bits seen while armed; a fall that happened before arming, setpoint writes and event pulses do not trigger.
- R6: In event mode (cfg_mode = 3) base ticks are not stored until an ev_trig pulse arrives after arming.
- R7: Outside immediate mode, the first cfg_delay base ticks after the trigger are skipped and the next one is stored.
- R8: After a stored tick, the next stored tick is the (cfg_rate+1)-th base tick that follows it.
- R9: Each stored tick writes, at consecutive addresses starting from 0 for the capture, the chan_data word of every enabled channel (word c is chan_data[c*DW +: DW]), in ascending channel order; a zero mask stores nothing but still counts sets.
- R10: After cfg_samples sets have been stored (a count of 0 acts as 1), busy falls, done_pulse is high for exactly one cycle, and later ticks write nothing.
- R11: stop_wr while busy suppresses any write in that cycle, clears busy on the next cycle with a one-cycle done_pulse, and no write follows.
- R12: No write goes to an address at or beyond 2^AW; a capture that would need one ends with busy cleared and a done_pulse after exactly 2^AW writes.
- R13: chan_count equals the number of 1 bits in cfg_mask, and mem_size_k equals 2^AW / 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Trigger source: 0 immediate, 1 ramp start, 2 ramp end, 3 external event |
| cfg_mask | input | NCH | Enabled-channel mask, bit c enables channel c |
| cfg_rate | input | RATE_W | Decimation N: one tick in N+1 is stored |
| cfg_delay | input | DLY_W | Base ticks skipped after the trigger |
| cfg_samples | input | CNT_W | Sample sets to store per capture |
| arm_wr | input | 1 | Pulse: write of 1 to the arm bit |
| stop_wr | input | 1 | Pulse: write of 1 to the abort bit |
| base_tick | input | 1 | One-cycle base sample strobe |
| chan_data | input | NCH*DW | Sample words, channel c at bits c*DW +: DW |
| setpoint_wr | input | 1 | Pulse: a new setpoint was written |
| ramping | input | NCH | Per-channel ramp-in-progress flags |
| ev_trig | input | 1 | Pulse: selected external event |
| mem_we | output | 1 | Sample memory write enable |
| mem_addr | output | AW | Sample memory write address |
| mem_wdata | output | DW | Sample memory write data |
| busy | output | 1 | Capture armed or running; arm-bit readback |
| done_pulse | output | 1 | One-cycle pulse on completion, abort or full memory |
| chan_count | output | $clog2(NCH+1) | Number of channels enabled in cfg_mask |
| mem_size_k | output | 8 | Memory size in units of 1024 words |

## Verification
The hardest situation to reach is an abort landing in the middle of a sample set, after some channels of that set are written and before the rest, because it needs the stop pulse placed on an exact cycle relative to the accepted tick. The bench drives the tick and the stop from a single task, counting edges from the tick to the cycle after the first channel write, so exactly one word of the third set lands. Ramp-end triggering is the other awkward case: the ramping flags are raised before arming and dropped only after a few ignored ticks, and a separate run drops them before arming to show that a stale fall does not fire. A full-memory run with a sample count larger than the memory holds reaches the overflow stop.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

    typedef enum logic [1:0] {
        TM_IMMEDIATE  = 2'd0,
        TM_RAMP_START = 2'd1,
        TM_RAMP_END   = 2'd2,
        TM_EVENT      = 2'd3
    } trig_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DELAY,
        ST_WAIT_TICK,
        ST_SCAN
    } cap_state_e;

endpackage

// File: rtl/wcap_trigger.sv
module wcap_trigger
    import wcap_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  trig_mode_e       mode,
    input  logic             listening,
    input  logic             setpoint_wr,
    input  logic [NCH-1:0]   ramping,
    input  logic             ev_trig,
    output logic             hit
);

    logic ramp_any;
    logic ramp_any_q;
    logic ramp_fall;

    assign ramp_any  = |ramping;
    assign ramp_fall = ramp_any_q && !ramp_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_any_q <= 1'b0;
        end else begin
            ramp_any_q <= ramp_any;
        end
    end

    always_comb begin
        hit = 1'b0;
        if (listening) begin
            unique case (mode)
                TM_IMMEDIATE:  hit = 1'b1;
                TM_RAMP_START: hit = setpoint_wr;
                TM_RAMP_END:   hit = ramp_fall;
                TM_EVENT:      hit = ev_trig;
                default:       hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wcap_chan_scan.sv
module wcap_chan_scan #(
    parameter int NCH = 32,
    parameter int DW  = 32,
    parameter int CW  = $clog2(NCH),
    parameter int PW  = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0]    mask,
    input  logic [PW-1:0]     ptr,
    input  logic [NCH*DW-1:0] samples,
    output logic              found,
    output logic [CW-1:0]     idx,
    output logic [DW-1:0]     data
);

    // Lowest enabled channel at or above ptr; descending loop lets the
    // lowest match win.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (PW'(i) >= ptr)) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end

    assign data = samples[idx*DW +: DW];

endmodule

// File: rtl/wave_capture.sv
module wave_capture
    import wcap_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int DW     = 32,
    parameter int AW     = 16,
    parameter int RATE_W = 10,
    parameter int DLY_W  = 10,
    parameter int CNT_W  = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cfg_mode,
    input  logic [NCH-1:0]             cfg_mask,
    input  logic [RATE_W-1:0]          cfg_rate,
    input  logic [DLY_W-1:0]           cfg_delay,
    input  logic [CNT_W-1:0]           cfg_samples,
    input  logic                       arm_wr,
    input  logic                       stop_wr,
    input  logic                       base_tick,
    input  logic [NCH*DW-1:0]          chan_data,
    input  logic                       setpoint_wr,
    input  logic [NCH-1:0]             ramping,
    input  logic                       ev_trig,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_wdata,
    output logic                       busy,
    output logic                       done_pulse,
    output logic [$clog2(NCH+1)-1:0]   chan_count,
    output logic [7:0]                 mem_size_k
);

    localparam int CW        = $clog2(NCH);
    localparam int PW        = $clog2(NCH + 1);
    localparam int CCW       = $clog2(NCH + 1);
    localparam int MEM_WORDS = 2 ** AW;
    localparam int SIZE_K    = MEM_WORDS / 1024;

    cap_state_e          state_q, state_d;
    trig_mode_e          mode_q;
    logic [NCH-1:0]      mask_q;
    logic [RATE_W-1:0]   rate_q, dec_cnt;
    logic [DLY_W-1:0]    dly_q, dly_cnt;
    logic [CNT_W-1:0]    nsamp_q, sets_q;
    logic [PW-1:0]       ptr_q;
    logic [AW:0]         addr_q;
    logic                done_q;

    logic                trig_hit;
    logic                scan_found;
    logic [CW-1:0]       scan_idx;
    logic [DW-1:0]       scan_data;
    logic                mem_full;
    logic                last_set;
    logic                tick_store;
    logic                delay_over;

    assign mem_full   = addr_q[AW];
    assign last_set   = ({1'b0, sets_q} + (CNT_W + 1)'(1)) >= {1'b0, nsamp_q};
    assign tick_store = base_tick && (dec_cnt == '0);
    assign delay_over = base_tick && (dly_cnt == DLY_W'(1));

    wcap_trigger #(
        .NCH(NCH)
    ) u_trigger (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .listening   (state_q == ST_ARMED),
        .setpoint_wr (setpoint_wr),
        .ramping     (ramping),
        .ev_trig     (ev_trig),
        .hit         (trig_hit)
    );

    wcap_chan_scan #(
        .NCH(NCH),
        .DW (DW),
        .CW (CW),
        .PW (PW)
    ) u_scan (
        .mask    (mask_q),
        .ptr     (ptr_q),
        .samples (chan_data),
        .found   (scan_found),
        .idx     (scan_idx),
        .data    (scan_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_wr) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (stop_wr) begin
                    state_d = ST_IDLE;
                end else if (trig_hit) begin
                    state_d = (mode_q == TM_IMMEDIATE || dly_q == '0) ? ST_WAIT_TICK : ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (stop_wr)         state_d = ST_IDLE;
                else if (delay_over) state_d = ST_WAIT_TICK;
            end
            ST_WAIT_TICK: begin
                if (stop_wr)         state_d = ST_IDLE;
                else if (tick_store) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (stop_wr) begin
                    state_d = ST_IDLE;
                end else if (scan_found) begin
                    if (mem_full) state_d = ST_IDLE;
                end else begin
                    state_d = last_set ? ST_IDLE : ST_WAIT_TICK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= TM_IMMEDIATE;
            mask_q  <= '0;
            rate_q  <= '0;
            dly_q   <= '0;
            nsamp_q <= '0;
            dly_cnt <= '0;
            dec_cnt <= '0;
            sets_q  <= '0;
            ptr_q   <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            unique case (state_q)
                ST_IDLE: begin
                    if (arm_wr) begin
                        mode_q  <= trig_mode_e'(cfg_mode);
                        mask_q  <= cfg_mask;
                        rate_q  <= cfg_rate;
                        dly_q   <= cfg_delay;
                        nsamp_q <= cfg_samples;
                        addr_q  <= '0;
                        sets_q  <= '0;
                        ptr_q   <= '0;
                        dec_cnt <= '0;
                    end
                end
                ST_ARMED: begin
                    if (state_d == ST_DELAY) dly_cnt <= dly_q;
                end
                ST_DELAY: begin
                    if (base_tick) dly_cnt <= dly_cnt - DLY_W'(1);
                end
                ST_WAIT_TICK: begin
                    if (base_tick) begin
                        if (dec_cnt == '0) begin
                            dec_cnt <= rate_q;
                            ptr_q   <= '0;
                        end else begin
                            dec_cnt <= dec_cnt - RATE_W'(1);
                        end
                    end
                end
                ST_SCAN: begin
                    if (!stop_wr) begin
                        if (scan_found) begin
                            if (!mem_full) begin
                                addr_q <= addr_q + (AW + 1)'(1);
                                ptr_q  <= PW'(scan_idx) + PW'(1);
                            end
                        end else begin
                            sets_q <= sets_q + CNT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        mem_we     = (state_q == ST_SCAN) && scan_found && !mem_full && !stop_wr;
        mem_addr   = addr_q[AW-1:0];
        mem_wdata  = scan_data;
        busy       = (state_q != ST_IDLE);
        done_pulse = done_q;
        mem_size_k = 8'(SIZE_K);
        chan_count = '0;
        for (int i = 0; i < NCH; i++) begin
            chan_count = chan_count + CCW'(cfg_mask[i]);
        end
    end

endmodule

// File: rtl/wcap_checker.sv
module wcap_checker #(
    parameter int NCH = 32,
    parameter int AW  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      busy,
    input logic                      mem_we,
    input logic [AW-1:0]             mem_addr,
    input logic                      done_pulse,
    input logic                      stop_wr,
    input logic [NCH-1:0]            cfg_mask,
    input logic [$clog2(NCH+1)-1:0]  chan_count
);

    localparam logic [AW+1:0] MEMW = (AW + 2)'(2 ** AW);

    logic [AW+1:0] wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wr_cnt <= '0;
        else if (!busy)  wr_cnt <= '0;
        else if (mem_we) wr_cnt <= wr_cnt + (AW + 2)'(1);
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we); // R2

    AST_PACKED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == wr_cnt[AW-1:0])); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_cnt < MEMW)); // R12

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R10

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!busy && $past(busy))); // R10

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop_wr) |=> (!busy && done_pulse)); // R11

    AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |-> !mem_we); // R11

    AST_CHAN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        chan_count == $countones(cfg_mask)); // R13

endmodule

bind wave_capture wcap_checker #(
    .NCH(NCH),
    .AW (AW)
) u_wcap_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .done_pulse (done_pulse),
    .stop_wr    (stop_wr),
    .cfg_mask   (cfg_mask),
    .chan_count (chan_count)
);

// File: tb/wave_capture_test.sv
`timescale 1ns/1ps
module wave_capture_test;

    localparam int NCH    = 8;
    localparam int DW     = 16;
    localparam int AW     = 11;
    localparam int RATE_W = 10;
    localparam int DLY_W  = 10;
    localparam int CNT_W  = 24;
    localparam int CCW    = $clog2(NCH + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          cfg_mode = '0;
    logic [NCH-1:0]      cfg_mask = '0;
    logic [RATE_W-1:0]   cfg_rate = '0;
    logic [DLY_W-1:0]    cfg_delay = '0;
    logic [CNT_W-1:0]    cfg_samples = '0;
    logic                arm_wr = 1'b0;
    logic                stop_wr = 1'b0;
    logic                base_tick = 1'b0;
    logic [NCH*DW-1:0]   chan_data = '0;
    logic                setpoint_wr = 1'b0;
    logic [NCH-1:0]      ramping = '0;
    logic                ev_trig = 1'b0;
    logic                mem_we;
    logic [AW-1:0]       mem_addr;
    logic [DW-1:0]       mem_wdata;
    logic                busy;
    logic                done_pulse;
    logic [CCW-1:0]      chan_count;
    logic [7:0]          mem_size_k;

    int checks = 0;
    int fails  = 0;
    int wr_n   = 0;
    int done_n = 0;
    logic [DW-1:0] log_data [0:4095];
    logic [AW-1:0] log_addr [0:4095];

    always #2.5 clk = ~clk;

    wave_capture #(
        .NCH(NCH), .DW(DW), .AW(AW),
        .RATE_W(RATE_W), .DLY_W(DLY_W), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode(cfg_mode), .cfg_mask(cfg_mask), .cfg_rate(cfg_rate),
        .cfg_delay(cfg_delay), .cfg_samples(cfg_samples),
        .arm_wr(arm_wr), .stop_wr(stop_wr), .base_tick(base_tick),
        .chan_data(chan_data), .setpoint_wr(setpoint_wr), .ramping(ramping),
        .ev_trig(ev_trig), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .done_pulse(done_pulse),
        .chan_count(chan_count), .mem_size_k(mem_size_k)
    );

    // Write and completion monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (wr_n < 4096) begin
                    log_data[wr_n] = mem_wdata;
                    log_addr[wr_n] = mem_addr;
                end
                wr_n++;
            end
            if (done_pulse) done_n++;
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic set_samples(input logic [7:0] j);
        for (int c = 0; c < NCH; c++) chan_data[c*DW +: DW] = {j, 8'(c)};
    endtask

    task automatic pulse_tick(input logic [7:0] j);
        set_samples(j);
        base_tick = 1'b1;
        cyc(1);
        base_tick = 1'b0;
        cyc(15);
    endtask

    task automatic arm();
        arm_wr = 1'b1;
        cyc(1);
        arm_wr = 1'b0;
    endtask

    task automatic run_case(input int mode, input logic [NCH-1:0] mask,
                            input int rate, input int dly, input int ns);
        string tag;
        int dly_eff, ns_eff, last_j, n, mism;
        tag = (mode == 0) ? "R3" : (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R6";
        cfg_mode = 2'(mode);
        cfg_mask = mask;
        cfg_rate = RATE_W'(rate);
        cfg_delay = DLY_W'(dly);
        cfg_samples = CNT_W'(ns);
        wr_n = 0;
        done_n = 0;
        if (mode == 2) ramping = '1;
        arm();
        cyc(3);
        if (mode != 0) begin
            pulse_tick(8'hEE);
            pulse_tick(8'hEE);
            check(busy && wr_n == 0, {tag, " no store before trigger"}, wr_n, 0);
            if (mode == 1) begin setpoint_wr = 1'b1; cyc(1); setpoint_wr = 1'b0; end
            if (mode == 2) begin ramping = '0; cyc(1); end
            if (mode == 3) begin ev_trig = 1'b1; cyc(1); ev_trig = 1'b0; end
            cyc(3);
        end
        dly_eff = (mode == 0) ? 0 : dly;
        ns_eff  = (ns == 0) ? 1 : ns;
        last_j  = dly_eff + (ns_eff - 1) * (rate + 1);
        for (int j = 0; j <= last_j + 2; j++) pulse_tick(8'(j));
        cyc(4);
        n = 0;
        mism = 0;
        for (int k = 0; k < ns_eff; k++) begin
            for (int c = 0; c < NCH; c++) begin
                if (mask[c]) begin
                    if (n < wr_n) begin
                        if (log_data[n] != {8'(dly_eff + k * (rate + 1)), 8'(c)} ||
                            log_addr[n] != AW'(n)) mism++;
                    end
                    n++;
                end
            end
        end
        check(wr_n == n, {tag, " R9 write count"}, wr_n, n);
        check(mism == 0, {tag, " R7/R8/R9 stored words"}, mism, 0);
        check(done_n == 1, {tag, " R10 done pulses"}, done_n, 1);
        check(!busy, {tag, " R10 busy cleared"}, busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(4);
        check(!busy, "R1 busy in reset", busy, 0);
        check(!mem_we, "R1 mem_we in reset", mem_we, 0);
        check(!done_pulse, "R1 done in reset", done_pulse, 0);
        rst_n = 1'b1;
        cyc(3);
        check(!busy && !mem_we && !done_pulse, "R1 idle after reset", busy, 0);

        // R13 exhaustive mask sweep for channel count
        for (int m = 0; m < (1 << NCH); m++) begin
            int pc;
            cfg_mask = NCH'(m);
            pc = 0;
            for (int b = 0; b < NCH; b++) pc += (m >> b) & 1;
            #1;
            check(chan_count == CCW'(pc), "R13 chan_count", chan_count, pc);
        end
        check(mem_size_k == 8'((2 ** AW) / 1024), "R13 mem_size_k", mem_size_k, (2 ** AW) / 1024);

        // Sweep of trigger modes, masks, rates, delays and counts (R3..R10)
        for (int mode = 0; mode < 4; mode++) begin
            for (int mi = 0; mi < 5; mi++) begin
                logic [NCH-1:0] mk;
                mk = (mi == 0) ? 8'h00 : (mi == 1) ? 8'h01 : (mi == 2) ? 8'hA5 :
                     (mi == 3) ? 8'hFF : 8'h80;
                for (int rt = 0; rt < 2; rt++)
                    for (int dl = 0; dl < 2; dl++)
                        for (int nsi = 0; nsi < 2; nsi++)
                            run_case(mode, mk, rt * 2, dl * 3, nsi * 3);
            end
        end

        // R5: a fall before arming does not trigger; other sources ignored
        wr_n = 0;
        done_n = 0;
        ramping = '1;
        cyc(2);
        ramping = '0;
        cyc(2);
        cfg_mode = 2'd2;
        cfg_mask = '1;
        cfg_rate = '0;
        cfg_delay = '0;
        cfg_samples = CNT_W'(2);
        arm();
        cyc(2);
        pulse_tick(8'd1);
        pulse_tick(8'd2);
        check(busy && wr_n == 0, "R5 stale fall ignored", wr_n, 0);
        setpoint_wr = 1'b1; cyc(1); setpoint_wr = 1'b0;
        ev_trig = 1'b1; cyc(1); ev_trig = 1'b0;
        pulse_tick(8'd3);
        check(busy && wr_n == 0, "R5 other sources ignored", wr_n, 0);
        stop_wr = 1'b1; cyc(1); stop_wr = 1'b0;
        cyc(3);
        check(!busy && done_n == 1, "R11 abort while armed", done_n, 1);

        // R11 abort mid-set, R2 re-arm while busy ignored
        wr_n = 0;
        done_n = 0;
        cfg_mode = 2'd0;
        cfg_mask = '1;
        cfg_samples = CNT_W'(100);
        arm();
        cyc(3);
        pulse_tick(8'd0);
        pulse_tick(8'd1);
        arm();
        cyc(2);
        check(busy, "R2 still busy after second arm", busy, 1);
        set_samples(8'd2);
        base_tick = 1'b1;
        cyc(1);
        base_tick = 1'b0;
        cyc(1);
        stop_wr = 1'b1;
        cyc(1);
        stop_wr = 1'b0;
        cyc(2);
        check(wr_n == 2 * NCH + 1, "R11 writes before abort", wr_n, 2 * NCH + 1);
        check(done_n == 1, "R11 done pulse on abort", done_n, 1);
        check(!busy, "R11 busy cleared on abort", busy, 0);
        check(log_addr[2*NCH] == AW'(2 * NCH) && log_data[2*NCH] == {8'd2, 8'd0},
              "R2 address continues after ignored arm", log_addr[2*NCH], 2 * NCH);
        pulse_tick(8'd3);
        pulse_tick(8'd4);
        check(wr_n == 2 * NCH + 1, "R11 no writes after abort", wr_n, 2 * NCH + 1);

        // R12 memory full
        wr_n = 0;
        done_n = 0;
        cfg_samples = CNT_W'(300);
        arm();
        cyc(3);
        for (int j = 0; j < 262; j++) pulse_tick(8'(j));
        check(wr_n == 2 ** AW, "R12 writes at full", wr_n, 2 ** AW);
        check(done_n == 1, "R12 done pulse at full", done_n, 1);
        check(!busy, "R12 busy cleared at full", busy, 0);
        check(log_addr[2**AW-1] == AW'(2 ** AW - 1), "R12 last address",
              log_addr[2**AW-1], 2 ** AW - 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule